// File: doc/BRIEF.md
# Processor Status Flag Register with Working-Register Address

This block keeps the 8-bit status byte of an 8051-family core. After each ALU operation it updates the arithmetic flags. The core supplies an operation code, the two operands, the upper byte of the ALU result (used by multiply) and the current accumulator value. Carry, auxiliary carry and overflow each follow their own rule for each operation. The parity bit is not stored. It follows the accumulator input combinationally, so it is correct in every cycle.

Two bank-select bits in the status byte pick one of four banks of eight working registers. The block combines them with a 3-bit register index to form the internal data address of the selected register. Software can load the status byte directly. A direct load takes priority over any flag update in the same cycle. All stored flags update on the rising clock edge and appear on `psw_o` in the next cycle.

The status byte layout, from MSB to LSB, is: bit 7 carry, bit 6 auxiliary carry, bit 5 user flag, bit 4 bank-select high, bit 3 bank-select low, bit 2 overflow, bit 1 unassigned, bit 0 parity.

Top module: `psw_flag_unit`

## Requirements
- R1: While `rst_n` is low, and after reset, bits 7..1 of `psw_o` are 0. With the accumulator at 00h the byte reads 00h.
- R2: ADD (op 1) and ADDC (op 2) compute a+b+cin, where cin is 0 for ADD and the current carry for ADDC. Carry is set from bit 8 of the sum. Auxiliary carry is set from the carry out of bit 3. Overflow is set when the signed sum falls outside -128..127.
- R3: SUBB (op 3) computes a-b-carry. Carry is set on a borrow out of bit 7. Auxiliary carry is set on a borrow from bit 4. Overflow is set when the signed difference falls outside -128..127.
- R4: MUL (op 4) sets overflow when `res_hi_i` is non-zero and clears it otherwise. It clears carry and leaves auxiliary carry unchanged.
- R5: DIV (op 5) sets overflow when `b_i` is 00h and clears it otherwise. It clears carry and leaves auxiliary carry unchanged.
- R6: RLC (op 6) loads carry from `a_i[7]`. RRC (op 7) loads carry from `a_i[0]`. Both leave auxiliary carry and overflow unchanged.
- R7: CLRV (op 8) clears overflow and leaves every other stored bit unchanged.
- R8: `psw_o[0]` always equals the XOR of the eight `acc_i` bits, with no clock delay.
- R9: `reg_addr_o` equals 000, then bank-select high, then bank-select low, then `reg_idx_i`, read from MSB to LSB. Banks 0..3 therefore cover 00h-07h, 08h-0Fh, 10h-17h and 18h-1Fh.
- R10: When `wr_en_i` is high, bits 7..2 are loaded from `wr_data_i[7..2]` whatever the op code. Bit 1 always reads 0, and a write does not change parity.
- R11: The user flag (bit 5) and the bank-select bits change only through writes. Op 0 and codes 9..15 leave every stored bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code_i | input | 4 | Operation whose flags are applied this cycle |
| a_i | input | 8 | First operand (accumulator side) |
| b_i | input | 8 | Second operand / divisor |
| res_hi_i | input | 8 | High byte of the multiply product |
| acc_i | input | 8 | Current accumulator value, used for parity |
| wr_en_i | input | 1 | Direct write of the status byte |
| wr_data_i | input | 8 | Value for the direct write |
| reg_idx_i | input | 3 | Working register index Rn |
| psw_o | output | 8 | Status byte |
| reg_addr_o | output | 8 | Internal data address of the selected working register |

## Verification
The assertions assume that the op code, the operands and the write controls are stable around each rising edge. The bench drives every input on the falling edge, so this holds. The multiply assertion takes `res_hi_i` as given and does not check that it is really the product's upper byte. The bench therefore supplies arbitrary upper bytes, including 00h and non-zero values, and computes the expected overflow from the byte it drove. For carry-in dependent operations, the bench first sets carry through a direct write. This keeps each ADDC or SUBB case to a known starting carry.

// File: rtl/psw_pkg.sv
package psw_pkg;
    localparam int DATA_W  = 8;
    localparam int IDX_W   = 3;
    localparam int BANK_W  = 2;
    localparam int ADDR_W  = 8;
    localparam int NIB_W   = DATA_W / 2;

    localparam int BIT_CY  = 7;
    localparam int BIT_AC  = 6;
    localparam int BIT_F0  = 5;
    localparam int BIT_BKH = 4;
    localparam int BIT_BKL = 3;
    localparam int BIT_OV  = 2;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_ADDC = 4'd2,
        OP_SUBB = 4'd3,
        OP_MUL  = 4'd4,
        OP_DIV  = 4'd5,
        OP_RLC  = 4'd6,
        OP_RRC  = 4'd7,
        OP_CLRV = 4'd8
    } psw_op_e;

    typedef struct packed {
        logic              cy;
        logic              ac;
        logic              f0;
        logic [BANK_W-1:0] bank;
        logic              ov;
    } psw_state_t;
endpackage

// File: rtl/psw_flag_next.sv
module psw_flag_next
    import psw_pkg::*;
(
    input  logic [3:0]        op_code_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] res_hi_i,
    input  psw_state_t        cur_i,
    output psw_state_t        nxt_o
);
    logic [DATA_W:0]  wide_res;
    logic [NIB_W:0]   nib_res;
    logic             cin;

    always_comb begin
        nxt_o    = cur_i;
        cin      = 1'b0;
        wide_res = '0;
        nib_res  = '0;
        unique case (op_code_i)
            OP_ADD, OP_ADDC: begin
                cin      = (op_code_i == OP_ADDC) ? cur_i.cy : 1'b0;
                wide_res = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin};
                nib_res  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]}
                         + {{NIB_W{1'b0}}, cin};
                nxt_o.cy = wide_res[DATA_W];
                nxt_o.ac = nib_res[NIB_W];
                nxt_o.ov = (a_i[DATA_W-1] == b_i[DATA_W-1])
                         && (wide_res[DATA_W-1] != a_i[DATA_W-1]);
            end
            OP_SUBB: begin
                cin      = cur_i.cy;
                wide_res = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, cin};
                nib_res  = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]}
                         - {{NIB_W{1'b0}}, cin};
                nxt_o.cy = wide_res[DATA_W];
                nxt_o.ac = nib_res[NIB_W];
                nxt_o.ov = (a_i[DATA_W-1] != b_i[DATA_W-1])
                         && (wide_res[DATA_W-1] != a_i[DATA_W-1]);
            end
            OP_MUL: begin
                nxt_o.cy = 1'b0;
                nxt_o.ov = |res_hi_i;
            end
            OP_DIV: begin
                nxt_o.cy = 1'b0;
                nxt_o.ov = (b_i == '0);
            end
            OP_RLC:  nxt_o.cy = a_i[DATA_W-1];
            OP_RRC:  nxt_o.cy = a_i[0];
            OP_CLRV: nxt_o.ov = 1'b0;
            default: nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/psw_parity.sv
module psw_parity
    import psw_pkg::*;
(
    input  logic [DATA_W-1:0] acc_i,
    output logic              par_o
);
    always_comb par_o = ^acc_i;
endmodule

// File: rtl/psw_bank_addr.sv
module psw_bank_addr
    import psw_pkg::*;
(
    input  logic [BANK_W-1:0] bank_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int PAD_W = ADDR_W - BANK_W - IDX_W;

    always_comb addr_o = {{PAD_W{1'b0}}, bank_i, idx_i};

    always_comb begin
        AST_ADDR_IN_WINDOW: assert (addr_o < ADDR_W'(1 << (BANK_W + IDX_W))); // R9
    end
endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
    import psw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_code_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] res_hi_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  reg_idx_i,
    output logic [DATA_W-1:0] psw_o,
    output logic [ADDR_W-1:0] reg_addr_o
);
    psw_state_t state_q;
    psw_state_t state_nxt;
    psw_state_t wr_state;
    logic       par;

    psw_flag_next u_next (
        .op_code_i (op_code_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .res_hi_i  (res_hi_i),
        .cur_i     (state_q),
        .nxt_o     (state_nxt)
    );

    psw_parity u_par (
        .acc_i (acc_i),
        .par_o (par)
    );

    psw_bank_addr u_addr (
        .bank_i (state_q.bank),
        .idx_i  (reg_idx_i),
        .addr_o (reg_addr_o)
    );

    always_comb begin
        wr_state.cy   = wr_data_i[BIT_CY];
        wr_state.ac   = wr_data_i[BIT_AC];
        wr_state.f0   = wr_data_i[BIT_F0];
        wr_state.bank = {wr_data_i[BIT_BKH], wr_data_i[BIT_BKL]};
        wr_state.ov   = wr_data_i[BIT_OV];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state_q <= '0;
        else if (wr_en_i) state_q <= wr_state;
        else              state_q <= state_nxt;
    end

    always_comb begin
        psw_o = {state_q.cy, state_q.ac, state_q.f0, state_q.bank,
                 state_q.ov, 1'b0, par};
    end

    AST_SPARE_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        psw_o[1] == 1'b0); // R10
    AST_PARITY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        psw_o[0] == ^acc_i); // R8
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> psw_o[7:2] == $past(wr_data_i[7:2])); // R10
    AST_CLRV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && op_code_i == OP_CLRV) |=> !psw_o[BIT_OV]); // R7
    AST_MULDIV_NO_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && (op_code_i == OP_MUL || op_code_i == OP_DIV))
        |=> !psw_o[BIT_CY]); // R4
    AST_DIV_ZERO_OV: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && op_code_i == OP_DIV && b_i == '0) |=> psw_o[BIT_OV]); // R5
    AST_SW_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(psw_o[5:3])); // R11
endmodule

// File: tb/psw_flag_unit_tb.sv
module psw_flag_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] a = 8'd0, b = 8'd0, rhi = 8'd0, acc = 8'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [2:0] idx = 3'd0;
    logic [7:0] psw, raddr;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] mdl = 8'd0;   // expected bits 7..2, others zero

    always #4 clk = ~clk;

    psw_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_code_i(op_code), .a_i(a), .b_i(b),
        .res_hi_i(rhi), .acc_i(acc), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .reg_idx_i(idx), .psw_o(psw), .reg_addr_o(raddr)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h (op=%0d a=%02h b=%02h)",
                     req, act, exp, op_code, a, b);
        end
    endtask

    function automatic int sgn(input logic [7:0] v);
        return (v > 127) ? int'(v) - 256 : int'(v);
    endfunction

    // Apply one op: drive after negedge, one rising edge, check at following negedge.
    task automatic do_op(input string req, input logic [3:0] op, input logic [7:0] ia,
                         input logic [7:0] ib, input logic [7:0] ihi, input logic [7:0] iacc);
        int cin, s, sr;
        op_code = op; a = ia; b = ib; rhi = ihi; acc = iacc; wr_en = 1'b0;
        cin = mdl[7];
        case (op)
            4'd1, 4'd2: begin
                if (op == 4'd1) cin = 0;
                s  = int'(ia) + int'(ib) + cin;
                sr = sgn(ia) + sgn(ib) + cin;
                mdl[7] = (s > 255);
                mdl[6] = ((int'(ia) % 16) + (int'(ib) % 16) + cin) > 15;
                mdl[2] = (sr > 127) || (sr < -128);
            end
            4'd3: begin
                sr = sgn(ia) - sgn(ib) - cin;
                mdl[7] = int'(ia) < int'(ib) + cin;
                mdl[6] = (int'(ia) % 16) < (int'(ib) % 16) + cin;
                mdl[2] = (sr > 127) || (sr < -128);
            end
            4'd4: begin mdl[7] = 1'b0; mdl[2] = (ihi != 0); end
            4'd5: begin mdl[7] = 1'b0; mdl[2] = (ib == 0); end
            4'd6: mdl[7] = ia[7];
            4'd7: mdl[7] = ia[0];
            4'd8: mdl[2] = 1'b0;
            default: ;
        endcase
        @(negedge clk);
        check(req, psw, {mdl[7:2], 1'b0, ^iacc});
    endtask

    task automatic do_wr(input logic [7:0] d, input logic [3:0] op);
        op_code = op; a = 8'hFF; b = 8'hFF; rhi = 8'h01;
        wr_en = 1'b1; wr_data = d;
        mdl = {d[7:2], 2'b00};
        @(negedge clk);
        wr_en = 1'b0; op_code = 4'd0;
    endtask

    initial begin
        #1500000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        #3;
        check("R1 reset psw", psw, 8'h00);
        check("R9 reset addr", raddr, 8'h00);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", psw, 8'h00);

        // R2 ADD sweep
        for (int i = 0; i < 256; i++)
            for (int j = 0; j < 256; j += 3)
                do_op("R2 ADD", 4'd1, 8'(i), 8'(j), 8'h00, 8'(i + j));
        // R2 ADDC and R3 SUBB with both carry-in values
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 256; i += 5)
                for (int j = 0; j < 256; j += 7) begin
                    do_wr({c[0], 7'b0}, 4'd0);
                    do_op("R2 ADDC", 4'd2, 8'(i), 8'(j), 8'h00, 8'(j));
                    do_wr({c[0], 7'b0}, 4'd0);
                    do_op("R3 SUBB", 4'd3, 8'(i), 8'(j), 8'h00, 8'(i));
                end
        // R3 nibble and sign boundaries
        do_wr(8'h00, 4'd0); do_op("R3 SUBB 10-01", 4'd3, 8'h10, 8'h01, 8'h00, 8'h0F);
        do_wr(8'h00, 4'd0); do_op("R3 SUBB 80-01", 4'd3, 8'h80, 8'h01, 8'h00, 8'h7F);
        do_wr(8'h80, 4'd0); do_op("R3 SUBB 00-00 b", 4'd3, 8'h00, 8'h00, 8'h00, 8'hFF);

        // R4 MUL with AC preset both ways
        for (int k = 0; k < 2; k++)
            for (int h = 0; h < 256; h++) begin
                do_wr({1'b1, k[0], 6'b000001}, 4'd0);
                do_op("R4 MUL", 4'd4, 8'h12, 8'h34, 8'(h), 8'(h));
            end
        // R5 DIV
        for (int k = 0; k < 2; k++)
            for (int d = 0; d < 256; d++) begin
                do_wr({1'b1, k[0], 6'b000100}, 4'd0);
                do_op("R5 DIV", 4'd5, 8'h9A, 8'(d), 8'h00, 8'(d));
            end
        // R6 rotates through carry, AC/OV preset
        for (int i = 0; i < 256; i++) begin
            do_wr(8'h44, 4'd0);
            do_op("R6 RLC", 4'd6, 8'(i), 8'h00, 8'h00, 8'(i));
            do_op("R6 RRC", 4'd7, 8'(i), 8'h00, 8'h00, 8'(i));
        end
        // R7 CLRV
        do_wr(8'hFC, 4'd0);
        do_op("R7 CLRV", 4'd8, 8'h00, 8'h00, 8'h00, 8'h01);
        do_op("R7 CLRV again", 4'd8, 8'h00, 8'h00, 8'h00, 8'h00);

        // R11 idle codes change nothing
        do_wr(8'hFC, 4'd0);
        for (int op = 9; op < 16; op++)
            do_op("R11 idle code", 4'(op), 8'hFF, 8'hFF, 8'hFF, 8'h00);
        do_op("R11 NOP", 4'd0, 8'hFF, 8'hFF, 8'hFF, 8'h03);

        // R8 parity sweep, combinational
        for (int v = 0; v < 256; v++) begin
            acc = 8'(v);
            #1;
            check("R8 parity", {7'b0, psw[0]}, {7'b0, ^(8'(v))});
        end

        // R10 write priority over an ALU op, bit1 forced low
        for (int w = 0; w < 256; w++) begin
            acc = 8'h00;
            do_wr(8'(w), 4'd1);
            check("R10 write", psw, {8'(w) & 8'hFC});
        end

        // R9 bank address
        for (int bk = 0; bk < 4; bk++) begin
            do_wr(8'(bk << 3), 4'd0);
            for (int r = 0; r < 8; r++) begin
                idx = 3'(r);
                #1;
                check("R9 reg addr", raddr, 8'(bk * 8 + r));
            end
        end
        // R11 bank/F0 survive arithmetic
        do_wr(8'h38, 4'd0);
        do_op("R11 bank hold", 4'd1, 8'hFF, 8'h01, 8'h00, 8'h00);
        idx = 3'd5; #1;
        check("R11 addr after op", raddr, 8'h1D);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule